// File: doc/BRIEF.md
# Early-late gate bit synchronizer

This block recovers symbol timing from a serial bit stream that is oversampled by a faster sample clock. A phase counter splits each symbol into an early half and a late half, and three counters count how many samples were one in the early half, in the late half and over the whole symbol. At each symbol boundary the early count minus the late count forms a phase error. The majority decision on the whole-symbol count gives the bit value, and that value sets the sign of the error.

The signed per-symbol errors are summed in a saturating accumulator. When the magnitude of the accumulator goes strictly above a programmed threshold, the phase counter jumps forward or backward by a programmed number of sample clocks and the accumulator is cleared. A larger threshold gives a narrower loop bandwidth. A larger step gives faster pull-in at the cost of more jitter. The output clock is high for the early half of the symbol and low for the late half.

Top module: `el_bit_sync`

## Requirements
- R1: While reset is asserted and in the first sample clock after release, the phase is zero and data_clk_o is high. The first high interval after release lasts ratio_i/2 sample clocks.
- R2: With no correction, data_clk_o is high for ratio_i/2 sample clocks and then low for ratio_i/2 sample clocks, so one period is ratio_i sample clocks. ratio_i must be an even value from 4 to 254.
- R3: Per-symbol error rule. The symbol is decided as a one when its total count of one-samples is greater than ratio_i/2. For a one, the error is the early count minus the late count; otherwise the error is the late count minus the early count. Data equal to the inverse of data_clk_o therefore gives +ratio_i/2 per symbol. Data equal to data_clk_o gives -ratio_i/2 per symbol. Constant data gives zero.
- R4: A correction fires only when the magnitude of the accumulated error is strictly greater than thresh_i. Reaching exactly thresh_i does not fire a correction.
- R5: A positive accumulator advances the phase by step_i samples. The correction is applied at the edge that ends the second sample clock of the next symbol, so the high interval of that symbol lasts ratio_i/2 - step_i cycles.
- R6: A negative accumulator retards the phase by step_i samples, wrapping modulo ratio_i. From phase 1, a step of 3 with a ratio of 16 lands on phase 15: a high interval of 2 is followed by a low interval of 1.
- R7: When step_i is zero, no correction ever occurs, whatever the error.
- R8: When a correction fires, the accumulator restarts from zero. A constant error of +e per symbol with threshold T therefore corrects once every floor(T/e)+1 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Oversampled serial data |
| ratio_i | input | 8 | Sample clocks per symbol (even, 4..254) |
| thresh_i | input | 16 | Error magnitude threshold |
| step_i | input | 8 | Phase step in sample clocks |
| data_clk_o | output | 1 | Recovered data clock |

## Verification
The symbol wrap of the phase counter and a pending phase correction can fall in the same cycle. The end-of-symbol integration also has to cope with a symbol that a retard has lengthened or an advance has shortened. The bench drives the data as the inverse of, or equal to, the recovered clock, so the error per symbol is a known constant. It then lets corrections land a fixed two cycles into the following symbol. Each case is judged by the lengths of the successive high and low intervals of data_clk_o. These include the shortened or split interval caused by a correction and the error of the altered symbol that follows it.

// File: rtl/els_pkg.sv
package els_pkg;
  typedef enum logic {DIR_ADV = 1'b0, DIR_RET = 1'b1} step_dir_e;

  typedef struct packed {
    logic      valid;
    step_dir_e dir;
  } corr_t;
endpackage

// File: rtl/els_timing.sv
module els_timing
  import els_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int STEP_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [STEP_W-1:0]  step_i,
  input  corr_t              corr_i,
  output logic               early_win_o,
  output logic               sym_end_o
);
  localparam int PW = ((RATIO_W > STEP_W) ? RATIO_W : STEP_W) + 3;

  logic [RATIO_W-1:0] ph_q, ph_d;
  logic signed [PW-1:0] ph_s, st_s, rt_s, raw, tmp;
  logic wrap;

  always_comb begin
    ph_s = $signed({{(PW-RATIO_W){1'b0}}, ph_q});
    st_s = $signed({{(PW-STEP_W){1'b0}}, step_i});
    rt_s = $signed({{(PW-RATIO_W){1'b0}}, ratio_i});
    raw  = ph_s + PW'(1);
    if (corr_i.valid) raw = (corr_i.dir == DIR_ADV) ? raw + st_s : raw - st_s;
    wrap = 1'b0;
    tmp  = raw;
    if (raw >= rt_s) begin
      wrap = 1'b1;
      tmp  = raw - rt_s;
      if (tmp >= rt_s) tmp = '0;
    end else if (raw < 0) begin
      tmp = raw + rt_s;
      if (tmp < 0) tmp = '0;
    end
    ph_d = tmp[RATIO_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign early_win_o = ph_q < {1'b0, ratio_i[RATIO_W-1:1]};
  assign sym_end_o   = wrap;

  assert_phase_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < ratio_i);
endmodule

// File: rtl/els_integrators.sv
module els_integrators #(
  parameter int RATIO_W = 8,
  localparam int CW = RATIO_W + 1,
  localparam int EW = CW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 data_i,
  input  logic [RATIO_W-1:0]   ratio_i,
  input  logic                 early_win_i,
  input  logic                 sym_end_i,
  output logic                 err_valid_o,
  output logic signed [EW-1:0] err_o
);
  logic [CW-1:0] early_q, late_q, total_q;
  logic [CW-1:0] early_n, late_n, total_n, half;
  logic signed [EW-1:0] diff;
  logic bit_one;

  always_comb begin
    early_n = early_q + CW'(data_i & early_win_i);
    late_n  = late_q  + CW'(data_i & ~early_win_i);
    total_n = total_q + CW'(data_i);
    half    = CW'(ratio_i[RATIO_W-1:1]);
    bit_one = total_n > half;
    diff    = $signed({1'b0, early_n}) - $signed({1'b0, late_n});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q     <= '0;
      late_q      <= '0;
      total_q     <= '0;
      err_valid_o <= 1'b0;
      err_o       <= '0;
    end else begin
      err_valid_o <= sym_end_i;
      if (sym_end_i) begin
        early_q <= '0;
        late_q  <= '0;
        total_q <= '0;
        err_o   <= bit_one ? diff : -diff;
      end else begin
        early_q <= early_n;
        late_q  <= late_n;
        total_q <= total_n;
      end
    end
  end

  assert_one_err_per_symbol_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |=> !err_valid_o);
endmodule

// File: rtl/els_loop_filter.sv
module els_loop_filter
  import els_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int THR_W   = 16,
  parameter int STEP_W  = 8,
  parameter int ACC_W   = 18,
  localparam int EW = RATIO_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 err_valid_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [THR_W-1:0]     thresh_i,
  input  logic [STEP_W-1:0]    step_i,
  output corr_t                corr_o
);
  localparam logic signed [ACC_W:0] ACC_MAX = (ACC_W+1)'((1 << (ACC_W-1)) - 1);
  localparam logic signed [ACC_W:0] ACC_MIN = -ACC_MAX - 1;

  logic signed [ACC_W-1:0] acc_q, acc_sat;
  logic signed [ACC_W:0]   sum;
  logic [ACC_W-1:0]        mag;
  logic                    over;

  always_comb begin
    sum = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-EW){err_i[EW-1]}}, err_i};
    if (sum > ACC_MAX)      acc_sat = ACC_MAX[ACC_W-1:0];
    else if (sum < ACC_MIN) acc_sat = ACC_MIN[ACC_W-1:0];
    else                    acc_sat = sum[ACC_W-1:0];
    mag  = acc_sat[ACC_W-1] ? ACC_W'(-acc_sat) : ACC_W'(acc_sat);
    over = mag > ACC_W'(thresh_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      corr_o <= '{valid: 1'b0, dir: DIR_ADV};
    end else begin
      corr_o.valid <= 1'b0;
      if (err_valid_i) begin
        if (over && step_i != '0) begin
          corr_o.valid <= 1'b1;
          corr_o.dir   <= acc_sat[ACC_W-1] ? DIR_RET : DIR_ADV;
          acc_q        <= '0;
        end else begin
          acc_q <= acc_sat;
        end
      end
    end
  end

  assert_corr_needs_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o.valid |-> $past(step_i != '0));
  assert_acc_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o.valid |-> acc_q == '0);
  assert_corr_after_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o.valid |-> $past(err_valid_i));
endmodule

// File: rtl/el_bit_sync.sv
module el_bit_sync
  import els_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int THR_W   = 16,
  parameter int STEP_W  = 8,
  parameter int ACC_W   = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [THR_W-1:0]   thresh_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic               data_clk_o
);
  localparam int EW = RATIO_W + 2;

  corr_t                corr;
  logic                 early_win, sym_end, err_valid;
  logic signed [EW-1:0] err;

  els_timing #(.RATIO_W(RATIO_W), .STEP_W(STEP_W)) u_timing (
    .clk_i, .rst_ni, .ratio_i, .step_i,
    .corr_i      (corr),
    .early_win_o (early_win),
    .sym_end_o   (sym_end)
  );

  els_integrators #(.RATIO_W(RATIO_W)) u_integ (
    .clk_i, .rst_ni, .data_i, .ratio_i,
    .early_win_i (early_win),
    .sym_end_i   (sym_end),
    .err_valid_o (err_valid),
    .err_o       (err)
  );

  els_loop_filter #(.RATIO_W(RATIO_W), .THR_W(THR_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) u_filt (
    .clk_i, .rst_ni, .thresh_i, .step_i,
    .err_valid_i (err_valid),
    .err_i       (err),
    .corr_o      (corr)
  );

  assign data_clk_o = early_win;

  assert_clk_high_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> data_clk_o);
endmodule

// File: tb/el_bit_sync_tb_top.sv
module el_bit_sync_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [7:0] ratio_i = 8'd16;
  logic [15:0] thresh_i = '0;
  logic [7:0] step_i = '0;
  logic       data_clk_o;

  int n_run = 0, n_fail = 0;
  int hi_runs[0:15];
  int lo_runs[0:15];

  el_bit_sync dut_i (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int ratio, input int thr, input int step);
    rst_ni = 1'b0;
    ratio_i = 8'(ratio); thresh_i = 16'(thr); step_i = 8'(step);
    repeat (3) @(negedge clk_i);
    check("R1 clk high in reset", int'(data_clk_o), 1);
    rst_ni = 1'b1;
  endtask

  // mode 0: const 1, 1: inverse of data_clk_o, 2: equal to data_clk_o
  task automatic collect(input int mode, input int cycles);
    int hi = 0, lo = 0, len = 0;
    logic cur = 1'b1;
    for (int i = 0; i < 16; i++) begin hi_runs[i] = 0; lo_runs[i] = 0; end
    for (int c = 0; c < cycles; c++) begin
      case (mode)
        0: data_i = 1'b1;
        1: data_i = ~data_clk_o;
        default: data_i = data_clk_o;
      endcase
      if (data_clk_o == cur) len++;
      else begin
        if (cur) begin if (hi < 16) hi_runs[hi] = len; hi++; end
        else     begin if (lo < 16) lo_runs[lo] = len; lo++; end
        cur = data_clk_o; len = 1;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic t_free_run(input int ratio, input int mode);
    do_reset(ratio, 0, 0);
    collect(mode, ratio * 9);
    check("R1 first high run", hi_runs[0], ratio / 2);
    for (int k = 0; k < 7; k++) begin
      check("R2/R7 high run", hi_runs[k], ratio / 2);
      check("R2/R7 low run", lo_runs[k], ratio / 2);
    end
  endtask

  task automatic t_zero_error;
    do_reset(16, 0, 3);
    collect(0, 16 * 9);
    for (int k = 0; k < 7; k++) check("R3 balanced gates, no step", hi_runs[k], 8);
  endtask

  task automatic t_advance(input int thr, input int period);
    do_reset(16, thr, 3);
    collect(1, 16 * 12);
    for (int k = 0; k < 10; k++)
      check("R3/R4/R5/R8 advance run", hi_runs[k],
            (k > 0 && (k % period) == 0) ? 5 : 8);
  endtask

  task automatic t_retard;
    do_reset(16, 20, 3);
    collect(2, 16 * 6);
    for (int k = 0; k < 3; k++) check("R6 runs before retard", hi_runs[k], 8);
    check("R3/R6 high run at retard", hi_runs[3], 2);
    check("R6 wrapped low run", lo_runs[3], 1);
    check("R6 next high run", hi_runs[4], 8);
  endtask

  initial begin
    t_free_run(16, 1);
    t_free_run(4, 2);
    t_free_run(254, 1);
    t_zero_error();
    t_advance(20, 3);
    t_advance(24, 4);
    t_retard();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule